// File: doc/BRIEF.md
# Interrupt Cause, Mask and Throttle Controller

This block gathers interrupt causes for a network device into one 32-bit cause register. A programmable mask selects which causes may reach the host. Bits 30:0 each latch one cause. Bit 31 is the asserted flag, and the single `irq` line follows it. The datapath raises causes through a post vector. A post can carry an immediate qualifier that skips moderation.

Host software reaches the block through plain register strobes that share one write-data bus. There are strobes for reading the cause register, writing it to clear causes, setting and clearing mask bits, loading the auto-mask value and loading the moderation interval. When the interval is non-zero, assertion is held off by a timer. The timer counts in units of `TICK_CYCLES` clock cycles, which is 256 ns at the intended clock. The timer is cancelled as soon as no unmasked cause is left. An auto-mask register can remove mask bits when the cause register is accessed, so that the handler runs with those sources quiet.

Every pin is a plain control or status pin. No data stream enters or leaves the block, so there is no valid/ready handshake and no back-pressure. A strobe acts on the single rising edge on which it is high.

Top module: `irq_throttle_ctrl`

## Requirements
- R1: After reset, the cause register, mask, auto-mask value and interval are all zero, and `irq` is low.
- R2: A rising edge with `post_vec` non-zero ORs those bits into cause bits 30:0. Bit 15 stands for transmit descriptor low, bit 16 for a small received packet and bit 17 for a received ack frame. `cause_q` always shows the register, and `irq` always equals `cause_q[31]`.
- R3: A read strobe returns the current `cause_q`. It then clears bits 30:0, but only when bit 31 was set or the whole mask was zero. Otherwise the read leaves the register unchanged.
- R4: A cause write clears each bit among 30:0 that is 1 in `acc_wdata` and leaves the other bits unchanged.
- R5: While `automask_en` is high, a cause write removes from the mask every bit that is set in the auto-mask value. A cause read does the same, but only if bit 31 was set. While `automask_en` is low, neither access changes the mask.
- R6: Posting a cause that is already pending has no effect, even with the immediate qualifier. The pending timer keeps its original expiry time.
- R7: When no cause is both pending and unmasked, bit 31 and `irq` are cleared and any running timer is cancelled. A later unmasked cause starts a fresh full interval.
- R8: With an unmasked cause pending and bit 31 clear, a zero interval asserts on the same edge. A non-zero interval N starts a timer if none is running, and bit 31 is set exactly N×`TICK_CYCLES` edges later.
- R9: A post with `post_now` high that brings a new cause cancels any running timer. It asserts bit 31 on that edge if an unmasked cause is then pending.
- R10: A mask-set strobe ORs `acc_wdata` into the mask, and a mask-clear strobe removes its 1 bits. The auto-mask strip of R5 applies after both.
- R11: Within one edge, register accesses apply first, posts second and the pending/timer evaluation last. A cause cleared by a read or write in that same edge is taken as new when it is posted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_wdata | input | 31 | Shared write data for all register strobes |
| cause_rd | input | 1 | Cause register read strobe |
| cause_wr | input | 1 | Cause register write-one-to-clear strobe |
| mask_set_wr | input | 1 | Mask set strobe |
| mask_clr_wr | input | 1 | Mask clear strobe |
| automask_wr | input | 1 | Auto-mask value load strobe |
| automask_en | input | 1 | Auto-mask enable level |
| interval_wr | input | 1 | Moderation interval load strobe (low IVL_W bits) |
| post_vec | input | 31 | Cause post bits from the datapath |
| post_now | input | 1 | Immediate qualifier for this cycle's post |
| cause_q | output | 32 | Cause register (bit 31 = asserted flag) |
| mask_q | output | 31 | Current mask |
| irq | output | 1 | Interrupt line to host |

## Verification
A host read that clears causes and a fresh post from the datapath can land on the same edge. The same is true of a cause write and a post of the very bit being cleared. The bench provokes both collisions by raising the strobe and `post_vec` together in one cycle while the flag is set. It then judges them on the next sample: the register must hold only the freshly posted bit, and with a zero interval the flag and `irq` must stay high.

// File: rtl/irq_thr_pkg.sv
`timescale 1ns/1ps
package irq_thr_pkg;
  localparam int CAUSE_W  = 31;
  localparam int FLAG_BIT = 31;

  typedef struct packed {
    logic start;
    logic cancel;
  } tmr_ctl_t;
endpackage

// File: rtl/irq_mask_bank.sv
`timescale 1ns/1ps
module irq_mask_bank #(
  parameter int CW = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] wdata,
  input  logic          set_wr,
  input  logic          clr_wr,
  input  logic          am_wr,
  input  logic          am_en,
  input  logic          cause_rd,
  input  logic          cause_wr,
  input  logic          flag_q,
  output logic [CW-1:0] mask_q,
  output logic [CW-1:0] mask_nxt
);
  logic [CW-1:0] am_q;

  // set, then clear, then auto strip
  always_comb begin
    mask_nxt = mask_q;
    if (set_wr) mask_nxt = mask_nxt | wdata;
    if (clr_wr) mask_nxt = mask_nxt & ~wdata;
    if (am_en && (cause_wr || (cause_rd && flag_q)))
      mask_nxt = mask_nxt & ~am_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      am_q   <= '0;
    end else begin
      mask_q <= mask_nxt;
      if (am_wr) am_q <= wdata;
    end
  end

  assert_automask_strip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_wr && am_en && !set_wr) |=> ((mask_q & $past(am_q)) == '0));

  assert_mask_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_wr && !clr_wr && !cause_wr && !cause_rd) |=> $stable(mask_q));
endmodule

// File: rtl/irq_mod_timer.sv
`timescale 1ns/1ps
module irq_mod_timer
  import irq_thr_pkg::*;
#(
  parameter int IVL_W       = 16,
  parameter int TICK_CYCLES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tmr_ctl_t         ctl,
  input  logic [IVL_W-1:0] load,
  output logic             run,
  output logic             expire
);
  localparam int PRE_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_CYCLES - 1);

  logic [PRE_W-1:0] pre;
  logic [IVL_W-1:0] cnt;
  logic             unit_done;

  assign unit_done = (pre == PRE_LAST);
  assign expire    = run && unit_done && (cnt == IVL_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0;
      pre <= '0;
      cnt <= '0;
    end else if (ctl.cancel) begin
      run <= 1'b0;
      pre <= '0;
    end else if (ctl.start) begin
      run <= 1'b1;
      pre <= '0;
      cnt <= load;
    end else if (run) begin
      if (expire) begin
        run <= 1'b0;
        pre <= '0;
      end else begin
        pre <= unit_done ? '0 : pre + PRE_W'(1);
        if (unit_done) cnt <= cnt - IVL_W'(1);
      end
    end
  end

  assert_start_runs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.start && !ctl.cancel) |=> run);

  assert_cancel_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.cancel |=> !run);
endmodule

// File: rtl/irq_throttle_ctrl.sv
`timescale 1ns/1ps
module irq_throttle_ctrl
  import irq_thr_pkg::*;
#(
  parameter int IVL_W       = 16,
  parameter int TICK_CYCLES = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CAUSE_W-1:0] acc_wdata,
  input  logic               cause_rd,
  input  logic               cause_wr,
  input  logic               mask_set_wr,
  input  logic               mask_clr_wr,
  input  logic               automask_wr,
  input  logic               automask_en,
  input  logic               interval_wr,
  input  logic [CAUSE_W-1:0] post_vec,
  input  logic               post_now,
  output logic [CAUSE_W:0]   cause_q,
  output logic [CAUSE_W-1:0] mask_q,
  output logic               irq
);
  logic [CAUSE_W-1:0] mask_nxt;
  logic [IVL_W-1:0]   ivl_q;
  logic [CAUSE_W:0]   cause_nxt;
  logic [CAUSE_W-1:0] fresh;
  logic               urgent, pend;
  tmr_ctl_t           tctl;
  logic               tmr_run, tmr_expire;

  irq_mask_bank #(.CW(CAUSE_W)) u_mask (
    .clk(clk), .rst_n(rst_n), .wdata(acc_wdata),
    .set_wr(mask_set_wr), .clr_wr(mask_clr_wr), .am_wr(automask_wr),
    .am_en(automask_en), .cause_rd(cause_rd), .cause_wr(cause_wr),
    .flag_q(cause_q[FLAG_BIT]), .mask_q(mask_q), .mask_nxt(mask_nxt)
  );

  irq_mod_timer #(.IVL_W(IVL_W), .TICK_CYCLES(TICK_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .ctl(tctl), .load(ivl_q),
    .run(tmr_run), .expire(tmr_expire)
  );

  // accesses, then posts, then evaluation
  always_comb begin
    cause_nxt = cause_q;
    if (cause_rd && (cause_q[FLAG_BIT] || mask_q == '0))
      cause_nxt[CAUSE_W-1:0] = '0;
    if (cause_wr)
      cause_nxt[CAUSE_W-1:0] = cause_nxt[CAUSE_W-1:0] & ~acc_wdata;
    fresh  = post_vec & ~cause_nxt[CAUSE_W-1:0];
    urgent = post_now && (fresh != '0);
    cause_nxt[CAUSE_W-1:0] = cause_nxt[CAUSE_W-1:0] | fresh;
    pend = (cause_nxt[CAUSE_W-1:0] & mask_nxt) != '0;
    tctl = '0;
    if (!pend) begin
      cause_nxt[FLAG_BIT] = 1'b0;
      tctl.cancel = tmr_run;
    end else if (urgent || ivl_q == '0 || tmr_expire) begin
      cause_nxt[FLAG_BIT] = 1'b1;
      tctl.cancel = tmr_run;
    end else if (!cause_nxt[FLAG_BIT] && !tmr_run) begin
      tctl.start = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_q <= '0;
      ivl_q   <= '0;
    end else begin
      cause_q <= cause_nxt;
      if (interval_wr) ivl_q <= acc_wdata[IVL_W-1:0];
    end
  end

  assign irq = cause_q[FLAG_BIT];

  assert_quiet_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((cause_q[CAUSE_W-1:0] & mask_q) == '0) |-> !irq);

  assert_timer_waits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_run |-> (!irq && ((cause_q[CAUSE_W-1:0] & mask_q) != '0)));

  assert_urgent_fires_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (post_now && ((post_vec & ~cause_q[CAUSE_W-1:0] & mask_q) != '0) &&
     !cause_rd && !cause_wr && !mask_set_wr && !mask_clr_wr) |=> irq);

  assert_write_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_wr && post_vec == '0) |=>
      ((cause_q[CAUSE_W-1:0] & $past(acc_wdata)) == '0));

  assert_post_sticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cause_rd && !cause_wr) |=>
      ((cause_q[CAUSE_W-1:0] & $past(post_vec)) == $past(post_vec)));
endmodule

// File: tb/tb_irq_throttle_ctrl.sv
`timescale 1ns/1ps
module tb_irq_throttle_ctrl;
  localparam int T = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [30:0] acc_wdata = '0;
  logic        cause_rd = 0, cause_wr = 0, mask_set_wr = 0, mask_clr_wr = 0;
  logic        automask_wr = 0, automask_en = 0, interval_wr = 0;
  logic [30:0] post_vec = '0;
  logic        post_now = 0;
  logic [31:0] cause_q;
  logic [30:0] mask_q;
  logic        irq;
  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  irq_throttle_ctrl #(.IVL_W(16), .TICK_CYCLES(T)) dut (
    .clk(clk), .rst_n(rst_n), .acc_wdata(acc_wdata), .cause_rd(cause_rd),
    .cause_wr(cause_wr), .mask_set_wr(mask_set_wr), .mask_clr_wr(mask_clr_wr),
    .automask_wr(automask_wr), .automask_en(automask_en),
    .interval_wr(interval_wr), .post_vec(post_vec), .post_now(post_now),
    .cause_q(cause_q), .mask_q(mask_q), .irq(irq)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cyc(2);
    rst_n = 1'b1;
  endtask

  task automatic post(input logic [30:0] v, input logic now);
    post_vec = v; post_now = now;
    cyc(1);
    post_vec = '0; post_now = 1'b0;
  endtask

  // 0 rd,1 wr,2 mset,3 mclr,4 am,5 ivl
  task automatic acc(input int kind, input logic [30:0] d);
    acc_wdata = d;
    case (kind)
      0: cause_rd = 1;
      1: cause_wr = 1;
      2: mask_set_wr = 1;
      3: mask_clr_wr = 1;
      4: automask_wr = 1;
      default: interval_wr = 1;
    endcase
    cyc(1);
    cause_rd = 0; cause_wr = 0; mask_set_wr = 0; mask_clr_wr = 0;
    automask_wr = 0; interval_wr = 0; acc_wdata = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    cyc(1);
    do_reset();
    // R1 reset state
    chk("R1 cause", cause_q, 32'h0);
    chk("R1 mask", {1'b0, mask_q}, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R2 post bits 15..17 with mask zero
    post(31'h0003_8000, 1'b0);
    chk("R2 cause bits", cause_q, 32'h0003_8000);
    chk("R2 irq masked", {31'b0, irq}, 32'h0);
    // R3 mask-zero read clears
    acc(0, '0);
    chk("R3 mask zero read", cause_q, 32'h0);

    // R10 mask set/clear
    acc(2, 31'h0F);
    chk("R10 set", {1'b0, mask_q}, 32'h0F);
    acc(3, 31'h05);
    chk("R10 clr", {1'b0, mask_q}, 32'h0A);

    // R8 zero interval asserts at once
    post(31'h2, 1'b0);
    chk("R8 zero ivl", cause_q, 32'h8000_0002);
    chk("R2 irq follows flag", {31'b0, irq}, 32'h1);
    // R3 read with flag set clears
    acc(0, '0);
    chk("R3 flag read", cause_q, 32'h0);
    chk("R7 line low", {31'b0, irq}, 32'h0);
    post(31'h4, 1'b0);
    acc(0, '0);
    chk("R3 no clear", cause_q, 32'h4);

    // R4 sweep of write patterns
    do_reset();
    for (int p = 0; p < 8; p++) begin
      post(31'h7, 1'b0);
      acc(1, 31'(p));
      chk("R4 w1c", cause_q, 32'(7 & ~p));
    end

    // R5 auto-mask
    do_reset();
    acc(4, 31'h3);
    acc(2, 31'hF);
    acc(1, '0);
    chk("R5 disabled", {1'b0, mask_q}, 32'hF);
    automask_en = 1;
    acc(0, '0);
    chk("R5 read no flag", {1'b0, mask_q}, 32'hF);
    acc(1, '0);
    chk("R5 write strip", {1'b0, mask_q}, 32'hC);
    acc(4, 31'h4);
    post(31'h4, 1'b0);
    chk("R5 setup irq", {31'b0, irq}, 32'h1);
    acc(0, '0);
    chk("R5 read strip", {1'b0, mask_q}, 32'h8);
    chk("R5 read clear", cause_q, 32'h0);
    automask_en = 0;

    // R8 interval sweep
    for (int n = 1; n <= 5; n++) begin
      do_reset();
      acc(2, 31'h1);
      acc(5, 31'(n));
      post(31'h1, 1'b0);
      cyc(n * T - 1);
      chk("R8 before expiry", {31'b0, irq}, 32'h0);
      cyc(1);
      chk("R8 at expiry", cause_q, 32'h8000_0001);
    end

    // R6 duplicate post, even immediate, has no effect
    do_reset();
    acc(2, 31'h1);
    acc(5, 31'd3);
    post(31'h1, 1'b0);
    cyc(5);
    post(31'h1, 1'b1);
    chk("R6 dup now", {31'b0, irq}, 32'h0);
    cyc(5);
    chk("R6 not early", {31'b0, irq}, 32'h0);
    cyc(1);
    chk("R6 original expiry", {31'b0, irq}, 32'h1);

    // R9 immediate post cancels timer and asserts
    do_reset();
    acc(2, 31'h3);
    acc(5, 31'd3);
    post(31'h1, 1'b0);
    cyc(2);
    post(31'h2, 1'b1);
    chk("R9 immediate", cause_q, 32'h8000_0003);
    // R7 masking everything drops the line
    acc(3, 31'h3);
    chk("R7 unmasked none", cause_q, 32'h3);

    // R7 cancelled timer restarts in full
    do_reset();
    acc(2, 31'h1);
    acc(5, 31'd2);
    post(31'h1, 1'b0);
    cyc(3);
    acc(3, 31'h1);
    chk("R7 cancel line", {31'b0, irq}, 32'h0);
    cyc(2);
    acc(2, 31'h1);
    cyc(7);
    chk("R7 no stale expiry", {31'b0, irq}, 32'h0);
    cyc(1);
    chk("R7 fresh interval", {31'b0, irq}, 32'h1);

    // R11 read-clear and post in the same cycle
    do_reset();
    acc(2, 31'h21);
    post(31'h1, 1'b0);
    cause_rd = 1; post_vec = 31'h20;
    cyc(1);
    cause_rd = 0; post_vec = '0;
    chk("R11 read+post", cause_q, 32'h8000_0020);
    // R11 write-clear and post of same bit
    cause_wr = 1; acc_wdata = 31'h20; post_vec = 31'h20;
    cyc(1);
    cause_wr = 0; acc_wdata = '0; post_vec = '0;
    chk("R11 write+post", cause_q, 32'h8000_0020);
    chk("R11 irq held", {31'b0, irq}, 32'h1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule